// File: doc/BRIEF.md
# PLL Divider Candidate Search Engine

This block walks the space of PLL pre-divider and multiplier settings for one input clock and one wanted DCO band. A single start pulse captures the input clock frequency, the lower and upper bound on the PLL output, the allowed window of the internal reference frequency, the highest DCO frequency the oscillator supports, and the largest legal pre-divider and multiplier. The engine then sweeps the pre-divider upward. For every pre-divider it derives the reference frequency and the matching multiplier bounds, and then sweeps the multiplier upward inside those bounds.

Each candidate appears on a valid/ready port with four fields: the pre-divider, the multiplier, the reference frequency and the DCO frequency. The consumer takes the candidate with ready high. A take bit sent with ready tells the engine whether the candidate is accepted or rejected. An accepted candidate ends the search with a one-cycle done pulse and found set. If every candidate is rejected, the done pulse comes with found clear. All divisions run one at a time on a shared multi-cycle restoring divider.

Top module: `pll_div_search`

## Requirements
- R1: While reset is held and right after it, busy, done and cand_valid are 0.
- R2: The first pre-divider offered is ceil(clkin_hz / fint_max_hz), raised to 1 if that is 0. Pre-dividers are visited in steps of +1.
- R3: The pre-divider never exceeds the smaller of floor(clkin_hz / fint_min_hz) and n_limit. If that bound is below the first value, the search offers nothing and fails.
- R4: cand_fint equals floor(clkin_hz / cand_n).
- R5: For each pre-divider the first multiplier is ceil(ceil(pll_min_hz / fint) / 2), raised to 1 if that is 0.
- R6: The last multiplier is the smallest of floor(floor(pll_max_hz / fint) / 2), floor(floor(dco_max_hz / fint) / 2) and m_limit.
- R7: cand_dco equals 2 × cand_m × cand_fint.
- R8: A pll_max_hz of 0 places no upper bound from that input.
- R9: The multiplier loop is inner and the pre-divider loop is outer. Both count upward, and no candidate is repeated or skipped.
- R10: While cand_valid is 1 and cand_ready is 0, cand_valid stays 1 and all candidate fields hold their values.
- R11: A transfer (cand_valid and cand_ready both 1) with cand_take = 1 produces done = 1 and found = 1 in the next cycle, and no further candidate follows.
- R12: Once every candidate has been transferred with cand_take = 0, done pulses for one cycle with found = 0.
- R13: A start pulse while busy is 1 is ignored. The running search continues on the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search and capture all setting inputs (honoured only when idle) |
| clkin_hz | input | W | Input clock frequency |
| pll_min_hz | input | W | Lowest wanted DCO frequency |
| pll_max_hz | input | W | Highest wanted DCO frequency, 0 for no bound |
| fint_min_hz | input | W | Lowest allowed reference frequency (nonzero) |
| fint_max_hz | input | W | Highest allowed reference frequency (nonzero) |
| dco_max_hz | input | W | Oscillator frequency ceiling |
| n_limit | input | NW | Largest pre-divider |
| m_limit | input | MW | Largest multiplier |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | With done: 1 if a candidate was accepted |
| cand_valid | output | 1 | Candidate on offer |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_take | input | 1 | Sent with cand_ready: 1 accepts, 0 rejects |
| cand_n | output | NW | Pre-divider of the candidate |
| cand_m | output | MW | Multiplier of the candidate |
| cand_fint | output | W | Reference frequency of the candidate |
| cand_dco | output | W | DCO frequency of the candidate |

## Verification
The assertions assume that fint_min_hz and fint_max_hz are nonzero, which keeps every division defined. They also assume that cand_take has meaning only together with cand_ready. The stimulus table uses only nonzero reference bounds, and the bench raises cand_take only in the cycle where it raises cand_ready. Within those limits the properties check candidate stability under back-pressure, the arithmetic relation among the four candidate fields, the pre-divider and multiplier limits, and the shape of the done pulse.

// File: rtl/pll_div_search_pkg.sv
// Shared types for the PLL divider search engine.
// Assumes nothing beyond the importing modules' parameters.
package pll_div_search_pkg;

    typedef enum logic [3:0] {
        S_IDLE,   // waiting for start
        S_NLO,    // first pre-divider from the reference ceiling
        S_NHI,    // last pre-divider from the reference floor
        S_NCHK,   // pre-divider loop test
        S_FINT,   // reference frequency for this pre-divider
        S_MLO,    // first multiplier from the output floor
        S_MHI,    // multiplier bound from the output ceiling
        S_MDCO,   // multiplier bound from the oscillator ceiling
        S_MCHK,   // multiplier loop test, loads the offer
        S_OFFER   // candidate on the port, waiting for transfer
    } srch_state_t;

endpackage

// File: rtl/pll_srch_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// go loads the operands. W cycles later fin pulses, and quo/rem hold
// until the next go. Assumes divisor is nonzero and go is not raised
// while a division is running.
module pll_srch_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    trial;

    // Partial remainder with the next dividend bit shifted in.
    always_comb trial = {rem_q, acc_q[W-1]};

    // One shift-and-subtract step per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                acc_q <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (trial >= {1'b0, dvs_q}) begin
                    rem_q <= W'(trial - {1'b0, dvs_q});
                    acc_q <= {acc_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[W-1:0];
                    acc_q <= {acc_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quo = acc_q;
    assign rem = rem_q;
endmodule

// File: rtl/pll_srch_offer.sv
// Candidate holding register for the valid/ready port.
// load captures a candidate and raises valid. A transfer (valid and ready)
// drops valid. The fields change only on load. Assumes load is never
// raised while valid is already high.
module pll_srch_offer #(
    parameter int W  = 32,
    parameter int NW = 8,
    parameter int MW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] in_n,
    input  logic [MW-1:0] in_m,
    input  logic [W-1:0]  in_fint,
    input  logic [W-1:0]  in_dco,
    input  logic          ready,
    output logic          valid,
    output logic [NW-1:0] out_n,
    output logic [MW-1:0] out_m,
    output logic [W-1:0]  out_fint,
    output logic [W-1:0]  out_dco
);
    // Valid flag: set by load, cleared by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)             valid <= 1'b0;
        else if (load)          valid <= 1'b1;
        else if (valid && ready) valid <= 1'b0;
    end

    // Candidate fields: written only on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_n    <= '0;
            out_m    <= '0;
            out_fint <= '0;
            out_dco  <= '0;
        end else if (load) begin
            out_n    <= in_n;
            out_m    <= in_m;
            out_fint <= in_fint;
            out_dco  <= in_dco;
        end
    end
endmodule

// File: rtl/pll_div_search.sv
// PLL divider candidate search engine (top).
// start captures the settings. The engine sweeps the pre-divider n upward
// and, for each n, the multiplier m upward, offering each pair with its
// reference and DCO frequency. One shared divider handles every division
// in sequence. Assumes nonzero reference bounds and W > NW, W > MW.
module pll_div_search
    import pll_div_search_pkg::*;
#(
    parameter int W  = 32,
    parameter int NW = 8,
    parameter int MW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  clkin_hz,
    input  logic [W-1:0]  pll_min_hz,
    input  logic [W-1:0]  pll_max_hz,
    input  logic [W-1:0]  fint_min_hz,
    input  logic [W-1:0]  fint_max_hz,
    input  logic [W-1:0]  dco_max_hz,
    input  logic [NW-1:0] n_limit,
    input  logic [MW-1:0] m_limit,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic          cand_valid,
    input  logic          cand_ready,
    input  logic          cand_take,
    output logic [NW-1:0] cand_n,
    output logic [MW-1:0] cand_m,
    output logic [W-1:0]  cand_fint,
    output logic [W-1:0]  cand_dco
);
    localparam int NCW = NW + 1;
    localparam int MCW = MW + 1;
    localparam int PW  = W + MCW + 1;

    srch_state_t state;
    logic [W-1:0]   clk_q, pmin_q, pmax_q, fmin_q, fmax_q, dmax_q;
    logic [NW-1:0]  nlim_q;
    logic [MW-1:0]  mlim_q;
    logic [NCW-1:0] n_q, n_stop_q;
    logic [MCW-1:0] m_q, m_stop_q;
    logic [W-1:0]   fint_q;
    logic           dv_wait;

    logic           dv_go, dv_fin;
    logic [W-1:0]   dv_a, dv_b, dv_quo, dv_rem;
    logic [W:0]     ceil_v, half_v, nfirst_v, mfirst_v;
    logic [W-1:0]   half_floor;
    logic [PW-1:0]  prod;
    logic           offer_load;

    pll_srch_divider #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go),
        .dividend(dv_a), .divisor(dv_b),
        .fin(dv_fin), .quo(dv_quo), .rem(dv_rem)
    );

    // Operand select for the shared divider and launch of each division.
    always_comb begin
        dv_a = '0;
        dv_b = '0;
        case (state)
            S_NLO:   begin dv_a = clk_q;  dv_b = fmax_q;     end
            S_NHI:   begin dv_a = clk_q;  dv_b = fmin_q;     end
            S_FINT:  begin dv_a = clk_q;  dv_b = W'(n_q);    end
            S_MLO:   begin dv_a = pmin_q; dv_b = fint_q;     end
            S_MHI:   begin dv_a = pmax_q; dv_b = fint_q;     end
            S_MDCO:  begin dv_a = dmax_q; dv_b = fint_q;     end
            default: ;
        endcase
        dv_go = (state inside {S_NLO, S_NHI, S_FINT, S_MLO, S_MHI, S_MDCO}) && !dv_wait;
    end

    // Rounded-up quotient, its rounded-up half, and the start values clamped to 1.
    always_comb begin
        ceil_v     = {1'b0, dv_quo} + (W+1)'(dv_rem != '0);
        half_v     = (ceil_v + (W+1)'(1)) >> 1;
        half_floor = dv_quo >> 1;
        nfirst_v   = (ceil_v == '0) ? (W+1)'(1) : ceil_v;
        mfirst_v   = (half_v == '0) ? (W+1)'(1) : half_v;
        prod       = (PW'(fint_q) * PW'(m_q)) << 1;
        offer_load = (state == S_MCHK) && (m_q <= m_stop_q);
    end

    // Search sequencer: captures the settings, runs the bound divisions, walks n and m.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            dv_wait  <= 1'b0;
            done     <= 1'b0;
            found    <= 1'b0;
            clk_q    <= '0; pmin_q <= '0; pmax_q <= '0;
            fmin_q   <= '0; fmax_q <= '0; dmax_q <= '0;
            nlim_q   <= '0; mlim_q <= '0;
            n_q      <= '0; n_stop_q <= '0;
            m_q      <= '0; m_stop_q <= '0;
            fint_q   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    clk_q  <= clkin_hz;
                    pmin_q <= pll_min_hz;
                    pmax_q <= (pll_max_hz == '0) ? '1 : pll_max_hz;
                    fmin_q <= fint_min_hz;
                    fmax_q <= fint_max_hz;
                    dmax_q <= dco_max_hz;
                    nlim_q <= n_limit;
                    mlim_q <= m_limit;
                    found  <= 1'b0;
                    state  <= S_NLO;
                end
                S_NLO, S_NHI, S_FINT, S_MLO, S_MHI, S_MDCO: begin
                    if (!dv_wait) begin
                        dv_wait <= 1'b1;
                    end else if (dv_fin) begin
                        dv_wait <= 1'b0;
                        case (state)
                            S_NLO: begin
                                n_q   <= (nfirst_v > (W+1)'(nlim_q)) ? NCW'(nlim_q) + 1'b1
                                                                  : NCW'(nfirst_v);
                                state <= S_NHI;
                            end
                            S_NHI: begin
                                n_stop_q <= (dv_quo > W'(nlim_q)) ? NCW'(nlim_q) : NCW'(dv_quo);
                                state    <= S_NCHK;
                            end
                            S_FINT: begin
                                fint_q <= dv_quo;
                                state  <= S_MLO;
                            end
                            S_MLO: begin
                                m_q   <= (mfirst_v > (W+1)'(mlim_q)) ? MCW'(mlim_q) + 1'b1
                                                                  : MCW'(mfirst_v);
                                state <= S_MHI;
                            end
                            S_MHI: begin
                                m_stop_q <= (half_floor > W'(mlim_q)) ? MCW'(mlim_q)
                                                                     : MCW'(half_floor);
                                state    <= S_MDCO;
                            end
                            default: begin
                                if (half_floor < W'(m_stop_q)) m_stop_q <= MCW'(half_floor);
                                state <= S_MCHK;
                            end
                        endcase
                    end
                end
                S_NCHK: begin
                    if (n_q > n_stop_q) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= S_FINT;
                    end
                end
                S_MCHK: begin
                    if (m_q > m_stop_q) begin
                        n_q   <= n_q + 1'b1;
                        state <= S_NCHK;
                    end else begin
                        state <= S_OFFER;
                    end
                end
                S_OFFER: begin
                    if (cand_valid && cand_ready) begin
                        if (cand_take) begin
                            done  <= 1'b1;
                            found <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            m_q   <= m_q + 1'b1;
                            state <= S_MCHK;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE);

    pll_srch_offer #(.W(W), .NW(NW), .MW(MW)) u_offer (
        .clk(clk), .rst_n(rst_n), .load(offer_load),
        .in_n(NW'(n_q)), .in_m(MW'(m_q)), .in_fint(fint_q), .in_dco(W'(prod)),
        .ready(cand_ready), .valid(cand_valid),
        .out_n(cand_n), .out_m(cand_m), .out_fint(cand_fint), .out_dco(cand_dco)
    );
endmodule

// File: rtl/pll_div_search_chk.sv
// Property checker for pll_div_search, attached by bind.
// Assumes nonzero reference bounds and cand_take used only with cand_ready.
module pll_div_search_chk #(
    parameter int W  = 32,
    parameter int NW = 8,
    parameter int MW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic          cand_valid,
    input logic          cand_ready,
    input logic          cand_take,
    input logic [NW-1:0] cand_n,
    input logic [MW-1:0] cand_m,
    input logic [W-1:0]  cand_fint,
    input logic [W-1:0]  cand_dco,
    input logic [W-1:0]  clk_q,
    input logic [NW-1:0] nlim_q,
    input logic [MW-1:0] mlim_q
);
    localparam int XW = 2 * W + 2;
    logic [XW-1:0] nf_x, dco_x;

    // Wide products for the arithmetic relations among the candidate fields.
    always_comb begin
        nf_x  = XW'(cand_fint) * XW'(cand_n);
        dco_x = (XW'(cand_fint) * XW'(cand_m)) << 1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cand_valid && !done && !busy));

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_n) && $stable(cand_m)
                                         && $stable(cand_fint) && $stable(cand_dco)));

    a_r4_fint_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (nf_x <= XW'(clk_q) && (XW'(clk_q) - nf_x) < XW'(cand_n)));

    a_r7_dco_product: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (XW'(cand_dco) == dco_x));

    a_r3_n_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_n >= NW'(1) && cand_n <= nlim_q));

    a_r6_m_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_m >= MW'(1) && cand_m <= mlim_q));

    a_r11_accept_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready && cand_take) |=> (done && found && !cand_valid));

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind pll_div_search pll_div_search_chk #(.W(W), .NW(NW), .MW(MW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .found(found),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_take(cand_take),
    .cand_n(cand_n), .cand_m(cand_m), .cand_fint(cand_fint), .cand_dco(cand_dco),
    .clk_q(clk_q), .nlim_q(nlim_q), .mlim_q(mlim_q)
);

// File: tb/sim_pll_div_search.sv
`timescale 1ns/1ps
module sim_pll_div_search;
    localparam int W = 32, NW = 8, MW = 12;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [W-1:0] clkin_hz = '0, pll_min_hz = '0, pll_max_hz = '0;
    logic [W-1:0] fint_min_hz = '0, fint_max_hz = '0, dco_max_hz = '0;
    logic [NW-1:0] n_limit = '0;
    logic [MW-1:0] m_limit = '0;
    logic busy, done, found, cand_valid;
    logic cand_ready = 1'b0, cand_take = 1'b0;
    logic [NW-1:0] cand_n;
    logic [MW-1:0] cand_m;
    logic [W-1:0] cand_fint, cand_dco;

    int nchk = 0, nerr = 0, cyc = 0;

    always #5 clk = ~clk;

    pll_div_search #(.W(W), .NW(NW), .MW(MW)) u0 (.*);

    typedef struct packed {
        int clkin, fmin, fmax, pmin, pmax, dmax, nlim, mlim, acc, rs;
    } vec_t;

    // acc: index of the candidate to accept (-1 rejects all); rs: start pulse while busy.
    localparam vec_t VECS [7] = '{
        '{100,  10,   40, 200, 300, 1000,    255, 4095, -1, 0},
        '{100,  10,   40, 200, 300, 1000,    255, 4095,  2, 0},
        '{60,   20,   30, 100,   0,  400,    255, 4095, -1, 1},
        '{50,   60,  100,  10, 100, 1000,    255, 4095, -1, 0},
        '{1000, 10,  500,   0,   0, 2000,      3,    2,  3, 0},
        '{120,  30,   40, 240, 240, 10000,   255, 4095, -1, 0},
        '{1000, 100, 1000,  0,   0, 1000000, 255,    1,  0, 0}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint cdiv(input longint a, input longint b);
        return (a + b - 1) / b;
    endfunction

    // Watchdog: an expired run counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    task automatic run_vec(input vec_t v);
        longint ns, ne, fint, ms, me, pm;
        int idx = 0;
        bit taken = 0;
        @(negedge clk);
        clkin_hz = W'(v.clkin); pll_min_hz = W'(v.pmin); pll_max_hz = W'(v.pmax);
        fint_min_hz = W'(v.fmin); fint_max_hz = W'(v.fmax); dco_max_hz = W'(v.dmax);
        n_limit = NW'(v.nlim); m_limit = MW'(v.mlim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ns = cdiv(v.clkin, v.fmax); if (ns < 1) ns = 1;                // R2
        ne = v.clkin / v.fmin; if (ne > v.nlim) ne = v.nlim;          // R3
        for (longint n = ns; n <= ne && !taken; n++) begin            // R9 outer loop
            fint = v.clkin / n;                                        // R4
            ms = cdiv(cdiv(v.pmin, fint), 2); if (ms < 1) ms = 1;     // R5
            pm = (v.pmax == 0) ? 64'hFFFF_FFFF : longint'(v.pmax);    // R8
            me = pm / fint / 2;                                        // R6
            if (v.dmax / fint / 2 < me) me = v.dmax / fint / 2;
            if (v.mlim < me) me = v.mlim;
            for (longint m = ms; m <= me && !taken; m++) begin        // R9 inner loop
                int w = 0;
                while (!cand_valid && !done && w < 3000) begin @(negedge clk); w++; end
                check(cand_valid == 1'b1, "R9 candidate missing", idx, idx);
                if (!cand_valid) return;
                check(cand_n == NW'(n), "R2/R3/R9 n", cand_n, n);
                check(cand_m == MW'(m), "R5/R6/R8 m", cand_m, m);
                check(cand_fint == W'(fint), "R4 fint", cand_fint, fint);
                check(cand_dco == W'(2 * m * fint), "R7 dco", cand_dco, 2 * m * fint);
                if (idx % 3 == 1) begin                                // R10 stall
                    if (v.rs != 0) begin                               // R13 start while busy
                        clkin_hz = 7777; fint_min_hz = 3; fint_max_hz = 5; pll_min_hz = 1;
                        start = 1'b1;
                    end
                    @(negedge clk); start = 1'b0;
                    @(negedge clk);
                    check(cand_valid && cand_n == NW'(n) && cand_m == MW'(m)
                          && cand_dco == W'(2 * m * fint), "R10 hold", cand_m, m);
                end
                cand_ready = 1'b1;
                cand_take  = (idx == v.acc);
                @(negedge clk);
                cand_ready = 1'b0;
                cand_take  = 1'b0;
                if (idx == v.acc) begin
                    taken = 1;
                    check(done && found, "R11 accept done/found", {done, found}, 3);
                    for (int k = 0; k < 5; k++) begin
                        @(negedge clk);
                        check(!cand_valid && !busy, "R11 no later candidate", cand_valid, 0);
                    end
                end
                idx++;
            end
        end
        if (!taken) begin
            int w = 0;
            while (!done && !cand_valid && w < 20000) begin @(negedge clk); w++; end
            check(done == 1'b1 && cand_valid == 1'b0, "R12/R3 end without extra candidate",
                  done, 1);
            check(found == 1'b0, "R12 found clear", found, 0);
            @(negedge clk);
            check(done == 1'b0, "R12 done one cycle", done, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !cand_valid, "R1 during reset", {busy, done, cand_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cand_valid, "R1 after reset", {busy, done, cand_valid}, 0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R1: reset in the middle of a search returns to the quiet state.
        @(negedge clk);
        clkin_hz = 100; fint_min_hz = 10; fint_max_hz = 40; pll_min_hz = 200;
        pll_max_hz = 300; dco_max_hz = 1000; n_limit = 255; m_limit = 4095;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cand_valid, "R1 mid-search reset", {busy, done, cand_valid}, 0);

        // R2: restart after the reset gives the first candidate again.
        run_vec(VECS[1]);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule